// File: doc/BRIEF.md
# Dual Condition Code Generator

This block sits beside a 64-bit integer adder/subtractor. It produces the sum or difference and keeps two condition-code sets from that one operation. The wide set describes the full 64-bit result. The narrow set describes only the low 32-bit result, as if the operation had been done on 32-bit operands. When the update strobe is high, one clock edge loads both sets together. As a result, code written for 32-bit and for 64-bit operands can share the same add and subtract operations.

A branch or overflow test names one of the two sets and a condition. The condition can be negative or positive, zero or non-zero, overflow or no overflow, carry or no carry. The block reports combinationally whether that condition holds in the chosen set. Instruction decode and branch target computation are handled elsewhere.

Top module: `dual_cc_unit`

## Requirements
- R1: `sum` is `op_a + op_b` when `sub_sel` is 0 and `op_a - op_b` when `sub_sel` is 1, modulo 2^64, and is combinational.
- R2: At a rising clock edge with `cc_we` high, the wide set and the narrow set are both loaded from the current operation at that same edge.
- R3: The wide set has N equal to result bit 63 and Z high exactly when all 64 result bits are zero.
- R4: The narrow set is computed only from result bits 31:0. N is bit 31, Z is high when bits 31:0 are all zero, and C is the carry out of bit 31.
- R5: The wide C is the carry out of bit 63. For a subtract, C is the carry of `op_a + ~op_b + 1`, so 1 means no borrow, that is, `op_a >= op_b` unsigned over the set's width.
- R6: V in each set flags signed overflow at that set's width. For an add, it is set when both operands have the same sign and the result's sign differs. For a subtract, it is set when the operands differ in sign and the result's sign differs from `op_a`.
- R7: At a rising edge with `cc_we` low, both flag sets keep their values.
- R8: While reset is asserted, both flag sets are zero.
- R9: `cond_true` is combinational. It tests the set chosen by `set_sel` (1 = wide, 0 = narrow) with `cond_sel`, using these codes: 0 = N, 1 = not N, 2 = Z, 3 = not Z, 4 = V, 5 = not V, 6 = C, 7 = not C.
- R10: Each flag output is packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released on the clock |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| sub_sel | input | 1 | 1 selects subtract, 0 selects add |
| cc_we | input | 1 | Load both flag sets at the next edge |
| cond_sel | input | 3 | Condition to test |
| set_sel | input | 1 | 1 tests the wide set, 0 the narrow set |
| sum | output | 64 | Adder/subtractor result |
| flags_wide | output | 4 | Wide set {N,Z,V,C} |
| flags_narrow | output | 4 | Narrow set {N,Z,V,C} |
| cond_true | output | 1 | Selected condition holds |

## Verification
The assertions assume that the operands and `sub_sel` stay steady from the drive point to the clock edge that samples them. They also assume that `cc_we` stays low until the internal reset has been released. The stimulus drives every input shortly after a rising edge and keeps the update strobe low for several cycles after reset. Between updates it sweeps all sixteen set and condition pairs with the strobe low. This keeps the stored flags stable while the test output is read.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  typedef enum logic [2:0] {
    CND_NEG   = 3'd0,
    CND_POS   = 3'd1,
    CND_ZERO  = 3'd2,
    CND_NZERO = 3'd3,
    CND_OVF   = 3'd4,
    CND_NOVF  = 3'd5,
    CND_CRY   = 3'd6,
    CND_NCRY  = 3'd7
  } cond_code_e;
endpackage

// File: rtl/dcc_rst_sync.sv
module dcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/dcc_addsub.sv
module dcc_addsub #(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic [DATA_W-1:0] b_eff,
  output logic              carry_low,
  output logic              carry_full
);
  localparam int HIGH_W = DATA_W - LOW_W;

  logic [LOW_W:0]  lo_t;
  logic [HIGH_W:0] hi_t;

  always_comb begin
    b_eff = sub ? ~b : b;
    lo_t  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + (LOW_W+1)'(sub);
    hi_t  = {1'b0, a[DATA_W-1:LOW_W]} + {1'b0, b_eff[DATA_W-1:LOW_W]}
          + (HIGH_W+1)'(lo_t[LOW_W]);
    res        = {hi_t[HIGH_W-1:0], lo_t[LOW_W-1:0]};
    carry_low  = lo_t[LOW_W];
    carry_full = hi_t[HIGH_W];
  end
endmodule

// File: rtl/dcc_flag_calc.sv
module dcc_flag_calc
  import dcc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] res,
  input  logic         a_msb,
  input  logic         b_msb,
  input  logic         carry,
  output cc_flags_t    flags
);
  always_comb begin
    flags.n = res[W-1];
    flags.z = (res == '0);
    flags.v = (a_msb == b_msb) && (res[W-1] != a_msb);
    flags.c = carry;
  end
endmodule

// File: rtl/dcc_cond_eval.sv
module dcc_cond_eval
  import dcc_pkg::*;
(
  input  cc_flags_t   fl,
  input  logic [2:0]  code,
  output logic        hit
);
  cond_code_e cc;

  always_comb begin
    cc = cond_code_e'(code);
    unique case (cc)
      CND_NEG:   hit =  fl.n;
      CND_POS:   hit = !fl.n;
      CND_ZERO:  hit =  fl.z;
      CND_NZERO: hit = !fl.z;
      CND_OVF:   hit =  fl.v;
      CND_NOVF:  hit = !fl.v;
      CND_CRY:   hit =  fl.c;
      CND_NCRY:  hit = !fl.c;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dual_cc_unit.sv
module dual_cc_unit
  import dcc_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LOW_W     = 32,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              sub_sel,
  input  logic              cc_we,
  input  logic [2:0]        cond_sel,
  input  logic              set_sel,
  output logic [DATA_W-1:0] sum,
  output logic [3:0]        flags_wide,
  output logic [3:0]        flags_narrow,
  output logic              cond_true
);
  localparam int NSETS = 2;

  logic              rst_core_n;
  logic [DATA_W-1:0] b_eff;
  logic              carry_low;
  logic              carry_full;
  cc_flags_t         calc_fl [NSETS];
  cc_flags_t         set_d   [NSETS];
  cc_flags_t         set_q   [NSETS];
  cc_flags_t         sel_fl;

  dcc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_core_n)
  );

  dcc_addsub #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_add (
    .a          (op_a),
    .b          (op_b),
    .sub        (sub_sel),
    .res        (sum),
    .b_eff      (b_eff),
    .carry_low  (carry_low),
    .carry_full (carry_full)
  );

  // index 0 = narrow set, index 1 = wide set
  for (genvar g = 0; g < NSETS; g++) begin : g_set
    localparam int SW = (g == 0) ? LOW_W : DATA_W;
    dcc_flag_calc #(.W(SW)) u_fc (
      .res   (sum[SW-1:0]),
      .a_msb (op_a[SW-1]),
      .b_msb (b_eff[SW-1]),
      .carry ((g == 0) ? carry_low : carry_full),
      .flags (calc_fl[g])
    );

    always_comb begin
      set_d[g] = set_q[g];
      if (cc_we) set_d[g] = calc_fl[g];
    end

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) set_q[g] <= '0;
      else             set_q[g] <= set_d[g];
    end
  end

  assign sel_fl       = set_sel ? set_q[1] : set_q[0];
  assign flags_wide   = set_q[1];
  assign flags_narrow = set_q[0];

  dcc_cond_eval u_cond (
    .fl   (sel_fl),
    .code (cond_sel),
    .hit  (cond_true)
  );

  // R7
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cc_we |=> ($stable(flags_wide) && $stable(flags_narrow)));

  // R4
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    cc_we |=> (flags_narrow[2] == ($past(sum[LOW_W-1:0]) == '0)));

  // R3
  wide_nz_excl_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(flags_wide[3] && flags_wide[2]));

  // R2
  zero_nest_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    flags_wide[2] |-> flags_narrow[2]);

  // R6
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cc_we && !sub_sel && (op_a[DATA_W-1] == op_b[DATA_W-1]))
      |=> (flags_wide[1] == ($past(sum[DATA_W-1]) != $past(op_a[DATA_W-1]))));
endmodule

// File: tb/sim_dual_cc_unit.sv
`timescale 1ns/1ps
module sim_dual_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        sub_sel = 1'b0, cc_we = 1'b0, set_sel = 1'b0;
  logic [2:0]  cond_sel = '0;
  logic [63:0] sum;
  logic [3:0]  flags_wide, flags_narrow;
  logic        cond_true;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  logic [3:0] m_wide, m_narrow;
  bit         last_we;

  always #2.5 clk = ~clk;

  dual_cc_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
    .cc_we(cc_we), .cond_sel(cond_sel), .set_sel(set_sel), .sum(sum),
    .flags_wide(flags_wide), .flags_narrow(flags_narrow), .cond_true(cond_true)
  );

  // R10 packing {N,Z,V,C}
  function automatic logic [3:0] ref_wide(logic [63:0] a, logic [63:0] b, logic s);
    logic [63:0] r;
    logic [64:0] e;
    logic        c;
    r = s ? a - b : a + b;
    e = s ? ({a[63], a} - {b[63], b}) : ({a[63], a} + {b[63], b});
    c = s ? (a >= b) : (r < a);
    return {r[63], r == 64'd0, e[64] != e[63], c};
  endfunction

  function automatic logic [3:0] ref_narrow(logic [63:0] a, logic [63:0] b, logic s);
    logic [31:0] x, y, r;
    logic [32:0] e;
    logic        c;
    x = a[31:0];
    y = b[31:0];
    r = s ? x - y : x + y;
    e = s ? ({x[31], x} - {y[31], y}) : ({x[31], x} + {y[31], y});
    c = s ? (x >= y) : (r < x);
    return {r[31], r == 32'd0, e[32] != e[31], c};
  endfunction

  function automatic logic ref_cond(logic [3:0] f, logic [2:0] c);
    logic bitv;
    case (c[2:1])
      2'd0:    bitv = f[3];
      2'd1:    bitv = f[2];
      2'd2:    bitv = f[1];
      default: bitv = f[0];
    endcase
    return c[0] ? !bitv : bitv;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference flag registers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wide   <= '0;
      m_narrow <= '0;
      last_we  <= 1'b0;
    end else begin
      last_we <= cc_we;
      if (cc_we) begin
        m_wide   <= ref_wide(op_a, op_b, sub_sel);
        m_narrow <= ref_narrow(op_a, op_b, sub_sel);
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      chk("R1 sum", sum, sub_sel ? op_a - op_b : op_a + op_b);
      if (last_we) begin
        chk("R2 both sets", {56'd0, flags_wide, flags_narrow}, {56'd0, m_wide, m_narrow});
        chk("R3 wide N", 64'(flags_wide[3]), 64'(m_wide[3]));
        chk("R3 wide Z", 64'(flags_wide[2]), 64'(m_wide[2]));
        chk("R6 wide V", 64'(flags_wide[1]), 64'(m_wide[1]));
        chk("R5 wide C", 64'(flags_wide[0]), 64'(m_wide[0]));
        chk("R4 narrow NZC", 64'({flags_narrow[3:2], flags_narrow[0]}),
            64'({m_narrow[3:2], m_narrow[0]}));
        chk("R6 narrow V", 64'(flags_narrow[1]), 64'(m_narrow[1]));
      end else begin
        chk("R7 hold", {56'd0, flags_wide, flags_narrow}, {56'd0, m_wide, m_narrow});
      end
      chk("R9 cond", 64'(cond_true),
          64'(ref_cond(set_sel ? m_wide : m_narrow, cond_sel)));
    end
  end

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic s,
                       input logic w, input logic [2:0] c, input logic ss);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; sub_sel = s; cc_we = w; cond_sel = c; set_sel = ss;
  endtask

  task automatic load_and_sweep(input logic [63:0] a, input logic [63:0] b, input logic s);
    drive(a, b, s, 1'b1, 3'd0, 1'b1);
    for (int ss = 0; ss < 2; ss++)
      for (int c = 0; c < 8; c++)
        drive(a, b, s, 1'b0, 3'(c), 1'(ss));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 reset wide", 64'(flags_wide), 64'd0);
    chk("R8 reset narrow", 64'(flags_narrow), 64'd0);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8 after release", {56'd0, flags_wide, flags_narrow}, 64'd0);
    chk_en = 1'b1;

    load_and_sweep(64'd1, 64'd1, 1'b0);
    load_and_sweep(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);          // wide zero+carry
    load_and_sweep(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);          // wide V
    load_and_sweep(64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0);          // narrow V only
    load_and_sweep(64'h0000_0001_FFFF_FFFF, 64'd1, 1'b0);          // narrow zero+carry
    load_and_sweep(64'd5, 64'd7, 1'b1);                            // borrow, negative
    load_and_sweep(64'd0, 64'd0, 1'b1);                            // zero, no borrow
    load_and_sweep(64'h8000_0000_0000_0000, 64'd1, 1'b1);          // wide sub V
    load_and_sweep(64'h0000_0000_8000_0000, 64'd1, 1'b1);          // narrow sub V
    load_and_sweep(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 4 == 1) b = a;
      if (i % 8 == 3) b = {a[63:32] + 32'd1, -a[31:0]};
      drive(a, b, 1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom));
    end

    drive(64'd0, 64'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    @(negedge clk);
    chk_en = 1'b0;
    done   = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule